// File: doc/BRIEF.md
# Disk DMA Sector Sequencer

This block steps a sector-addressed disk command (read, write or trim) through a series of DMA chunks whose byte lengths need not be sector multiples. A command is loaded with its kind, its first sector number and its sector count. The block then takes chunks from the DMA side one at a time. For each chunk it raises a request to the storage port that carries the command kind, the current sector and the chunk length, and then waits for the completion.

On a good completion the chunk length is rounded up to whole 512-byte sectors. The sector number moves forward by that amount and the remaining count falls by it. The end of the command and the end of the DMA are two separate events. The count reaching zero sets the ready and seek-complete status bits and fires the interrupt. The DMA side ends the DMA by offering a chunk of length zero. An error completion, or a request the storage port refuses, ends the DMA at once and sets an error flag.

Top module: `disk_dma_sequencer`

## Requirements
- R1: After reset, status is 0x00, and irq, dma_end, dma_err, req_valid and chunk_ready are all low.
- R2: cmd_load latches the command kind, the start sector and the sector count, sets status to 0x80 (bit 7 busy), clears dma_err and raises chunk_ready on the next cycle.
- R3: A nonzero-length chunk that is accepted produces a request whose req_op equals the loaded kind (0 read, 1 write, 2 trim). Its req_sector is the current sector and its req_bytes is the chunk length. The request is held steady until req_accept or req_reject.
- R4: A good completion adds ceil(length/512) to the current sector, with wrap-around at the sector width.
- R5: A good completion takes ceil(length/512) from the remaining count. The count never goes below zero.
- R6: When a good completion takes the count from nonzero to zero, status becomes 0x50 (bit 6 ready, bit 4 seek-complete) and irq is high for exactly one cycle. A completion while the count is already zero raises no irq.
- R7: A zero-length chunk issues no request. It pulses dma_end for one cycle and returns the block to idle, with chunk_ready low.
- R8: An error completion leaves the sector and the count unchanged and raises no irq. It sets dma_err, pulses dma_end and returns the block to idle.
- R9: A req_reject while a request is pending is handled the same as an error completion.
- R10: After a good completion the block is ready for the next chunk: chunk_ready is high and req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_load | input | 1 | Load a new command |
| cmd_op | input | 2 | Command kind: 0 read, 1 write, 2 trim |
| cmd_sector | input | 48 | First sector of the command |
| cmd_count | input | 16 | Sectors in the command |
| chunk_valid | input | 1 | DMA side offers a chunk |
| chunk_len | input | 24 | Chunk byte length, 0 ends the DMA |
| chunk_ready | output | 1 | Block takes a chunk this cycle |
| req_valid | output | 1 | Storage request pending |
| req_op | output | 2 | Request kind |
| req_sector | output | 48 | Request start sector |
| req_bytes | output | 24 | Request byte length |
| req_accept | input | 1 | Storage port takes the request |
| req_reject | input | 1 | Storage port cannot take the request |
| cpl_valid | input | 1 | Request completed |
| cpl_error | input | 1 | Completion carries an error |
| sector_out | output | 48 | Current sector number |
| count_out | output | 16 | Remaining sector count |
| status | output | 8 | Status byte |
| irq | output | 1 | One-cycle command-done interrupt |
| dma_end | output | 1 | One-cycle DMA-end pulse |
| dma_err | output | 1 | Sticky DMA error flag |

## Verification
The completion that finishes the command can also report an error. In that one cycle, the error path and the reaching of zero count both compete to act. The bench offers a final chunk large enough to bring the count to zero and returns it with cpl_error high. It then checks that dma_err and dma_end win, that no irq occurs, and that the sector and the count stay as they were. A later command of the same shape with a clean completion shows that the zero-count path still fires.

// File: rtl/disk_dma_sequencer.sv
module disk_dma_sequencer #(
  parameter int LBA_W = 48,
  parameter int CNT_W = 16,
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_load,
  input  logic [1:0]       cmd_op,
  input  logic [LBA_W-1:0] cmd_sector,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             chunk_valid,
  input  logic [LEN_W-1:0] chunk_len,
  output logic             chunk_ready,
  output logic             req_valid,
  output logic [1:0]       req_op,
  output logic [LBA_W-1:0] req_sector,
  output logic [LEN_W-1:0] req_bytes,
  input  logic             req_accept,
  input  logic             req_reject,
  input  logic             cpl_valid,
  input  logic             cpl_error,
  output logic [LBA_W-1:0] sector_out,
  output logic [CNT_W-1:0] count_out,
  output logic [7:0]       status,
  output logic             irq,
  output logic             dma_end,
  output logic             dma_err
);
  localparam int SHIFT  = 9;
  localparam int NSEC_W = LEN_W - SHIFT + 1;
  localparam int CMP_W  = (NSEC_W > CNT_W) ? NSEC_W : CNT_W;
  localparam logic [7:0] ST_BUSY = 8'h80;
  localparam logic [7:0] ST_DONE = 8'h50;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ISSUE, S_BUSY} state_t;

  state_t           state;
  logic [1:0]       op_q;
  logic [LBA_W-1:0] sector_q;
  logic [CNT_W-1:0] count_q;
  logic [LEN_W-1:0] len_q;

  logic [LEN_W:0]   len_up;
  logic [NSEC_W-1:0] nsec;
  logic [CMP_W-1:0] cnt_ext, nsec_ext;
  logic [CNT_W-1:0] count_next;
  logic             take, ok, fail;

  assign len_up     = {1'b0, len_q} + (LEN_W+1)'(511);
  assign nsec       = len_up[LEN_W:SHIFT];
  assign cnt_ext    = CMP_W'(count_q);
  assign nsec_ext   = CMP_W'(nsec);
  assign count_next = (nsec_ext >= cnt_ext) ? '0 : CNT_W'(cnt_ext - nsec_ext);

  assign chunk_ready = (state == S_WAIT);
  assign take        = chunk_ready && chunk_valid;
  assign ok          = (state == S_BUSY) && cpl_valid && !cpl_error;
  assign fail        = ((state == S_BUSY) && cpl_valid && cpl_error) ||
                       ((state == S_ISSUE) && req_reject);

  assign req_valid  = (state == S_ISSUE);
  assign req_op     = op_q;
  assign req_sector = sector_q;
  assign req_bytes  = len_q;
  assign sector_out = sector_q;
  assign count_out  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      sector_q <= '0;
      count_q  <= '0;
      len_q    <= '0;
      status   <= '0;
      irq      <= 1'b0;
      dma_end  <= 1'b0;
      dma_err  <= 1'b0;
    end else begin
      irq     <= 1'b0;
      dma_end <= 1'b0;
      if (cmd_load) begin
        state    <= S_WAIT;
        op_q     <= cmd_op;
        sector_q <= cmd_sector;
        count_q  <= cmd_count;
        status   <= ST_BUSY;
        dma_err  <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_WAIT:
            if (take) begin
              if (chunk_len == '0) begin
                dma_end <= 1'b1;
                state   <= S_IDLE;
              end else begin
                len_q <= chunk_len;
                state <= S_ISSUE;
              end
            end
          S_ISSUE:
            if (req_accept && !req_reject) state <= S_BUSY;
          S_BUSY: ;
          default: state <= S_IDLE;
        endcase
        if (ok) begin
          sector_q <= sector_q + LBA_W'(nsec);
          count_q  <= count_next;
          state    <= S_WAIT;
          if (count_q != '0 && count_next == '0) begin
            status <= ST_DONE;
            irq    <= 1'b1;
          end
        end
        if (fail) begin
          dma_err <= 1'b1;
          dma_end <= 1'b1;
          state   <= S_IDLE;
        end
      end
    end
  end

  assert_irq_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count_out == '0) && (status == ST_DONE));

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_accept && !req_reject && !cmd_load |=>
      req_valid && $stable(req_sector) && $stable(req_bytes));

  assert_end_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_end |=> !dma_end);

  assert_err_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_error && (state == S_BUSY) && !cmd_load |=>
      dma_err && dma_end && !irq && $stable(count_out));

  assert_reject_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_reject && !cmd_load |=> dma_err && dma_end && !req_valid);

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(chunk_ready && req_valid));
endmodule

// File: tb/tb_disk_dma_sequencer.sv
module tb_disk_dma_sequencer;
  logic        clk = 0, rst_n = 0;
  logic        cmd_load = 0;
  logic [1:0]  cmd_op = 0;
  logic [47:0] cmd_sector = 0;
  logic [15:0] cmd_count = 0;
  logic        chunk_valid = 0;
  logic [23:0] chunk_len = 0;
  logic        chunk_ready, req_valid;
  logic [1:0]  req_op;
  logic [47:0] req_sector, sector_out;
  logic [23:0] req_bytes;
  logic        req_accept = 0, req_reject = 0, cpl_valid = 0, cpl_error = 0;
  logic [15:0] count_out;
  logic [7:0]  status;
  logic        irq, dma_end, dma_err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  disk_dma_sequencer dut (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [47:0] lba;
    logic [15:0] cnt;
    logic [23:0] len;
    logic [47:0] exp_lba;
    logic [15:0] exp_cnt;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'd0, 48'd100,            16'd8,   24'd512,      48'd101,          16'd7, 1'b0},
    '{2'd1, 48'd0,              16'd4,   24'd513,      48'd2,            16'd2, 1'b0},
    '{2'd2, 48'h0000_FFFF_FFFF, 16'd1,   24'd1,        48'h0001_0000_0000, 16'd0, 1'b1},
    '{2'd0, 48'd7,              16'd3,   24'd1536,     48'd10,           16'd0, 1'b1},
    '{2'd1, 48'd50,             16'd2,   24'd4096,     48'd58,           16'd0, 1'b1},
    '{2'd0, 48'hFFFF_FFFF_FFFF, 16'd10,  24'd511,      48'd0,            16'd9, 1'b0},
    '{2'd2, 48'd1000,           16'd100, 24'hFF_FFFF,  48'd33768,        16'd0, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] op, input logic [47:0] lba, input logic [15:0] cnt);
    cmd_load = 1; cmd_op = op; cmd_sector = lba; cmd_count = cnt;
    @(negedge clk); cmd_load = 0;
  endtask

  task automatic offer(input logic [23:0] len);
    chunk_valid = 1; chunk_len = len;
    @(negedge clk); chunk_valid = 0;
  endtask

  task automatic accept();
    req_accept = 1; @(negedge clk); req_accept = 0;
  endtask

  task automatic complete(input logic err);
    cpl_valid = 1; cpl_error = err;
    @(negedge clk); cpl_valid = 0; cpl_error = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 outputs", {irq, dma_end, dma_err, req_valid, chunk_ready}, 5'b0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      do_load(VEC[i].op, VEC[i].lba, VEC[i].cnt);
      chk("R2 busy", status, 8'h80);
      chk("R2 ready", chunk_ready, 1'b1);
      offer(VEC[i].len);
      chk("R3 req_valid", req_valid, 1'b1);
      chk("R3 req_op", req_op, VEC[i].op);
      chk("R3 req_sector", req_sector, VEC[i].lba);
      chk("R3 req_bytes", req_bytes, VEC[i].len);
      @(negedge clk);
      chk("R3 hold", {req_valid, req_sector}, {1'b1, VEC[i].lba});
      accept();
      complete(1'b0);
      chk("R4 sector", sector_out, VEC[i].exp_lba);
      chk("R5 count", count_out, VEC[i].exp_cnt);
      chk("R6 irq", irq, VEC[i].exp_irq);
      if (VEC[i].exp_irq) chk("R6 status", status, 8'h50);
      chk("R10 ready", {chunk_ready, req_valid}, 2'b10);
      @(negedge clk);
      chk("R6 pulse", irq, 1'b0);
    end

    // multi-chunk command, then already-zero completion, then DMA end
    do_load(2'd1, 48'd20, 16'd3);
    offer(24'd512); accept(); complete(1'b0);
    chk("R5 count chunk1", count_out, 16'd2);
    chk("R6 no irq yet", irq, 1'b0);
    offer(24'd1024);
    chk("R3 second sector", req_sector, 48'd21);
    accept(); complete(1'b0);
    chk("R6 irq at zero", irq, 1'b1);
    chk("R4 sector after two", sector_out, 48'd23);
    offer(24'd100); accept(); complete(1'b0);
    chk("R6 no irq when zero", irq, 1'b0);
    chk("R5 floor", count_out, 16'd0);
    chk("R4 advance past end", sector_out, 48'd24);
    offer(24'd0);
    chk("R7 no request", req_valid, 1'b0);
    chk("R7 dma_end", dma_end, 1'b1);
    chk("R7 no err", dma_err, 1'b0);
    @(negedge clk);
    chk("R7 pulse", dma_end, 1'b0);
    chk("R7 idle", chunk_ready, 1'b0);

    // error on the completion that would finish the command
    do_load(2'd0, 48'd300, 16'd2);
    offer(24'd1024); accept(); complete(1'b1);
    chk("R8 dma_err", dma_err, 1'b1);
    chk("R8 dma_end", dma_end, 1'b1);
    chk("R8 no irq", irq, 1'b0);
    chk("R8 count kept", count_out, 16'd2);
    chk("R8 sector kept", sector_out, 48'd300);
    chk("R8 status", status, 8'h80);
    @(negedge clk);
    chk("R8 idle", {chunk_ready, dma_end}, 2'b00);

    // same shape, clean
    do_load(2'd0, 48'd300, 16'd2);
    chk("R2 err cleared", dma_err, 1'b0);
    offer(24'd1024); accept(); complete(1'b0);
    chk("R6 irq clean", irq, 1'b1);

    // reject
    do_load(2'd2, 48'd5, 16'd4);
    offer(24'd512);
    req_reject = 1; @(negedge clk); req_reject = 0;
    chk("R9 dma_err", dma_err, 1'b1);
    chk("R9 dma_end", dma_end, 1'b1);
    chk("R9 no req", {req_valid, chunk_ready}, 2'b00);
    chk("R9 count kept", count_out, 16'd4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule